// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit multiplies two 32-bit operands and adds the product into a 64-bit accumulator. The accumulator is kept as an upper word (HI) and a lower word (LO). Each operation is launched by a one-cycle start strobe. Three control bits travel with the strobe:

- whether the arithmetic is signed or unsigned;
- whether the sum is clamped on overflow;
- whether the new upper word or the new lower word is returned as the result.

The result appears on `rd_o` together with a one-cycle `done_o` pulse.

Software-style move operations can load either accumulator word directly through its own write strobe. Both words are always visible on read ports. In signed saturating mode the accumulator is clamped to the 32-bit signed range, sign-extended to 64 bits. In unsigned saturating mode a carry out of the 64-bit add pins the accumulator to all ones.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset, `hi_o`, `lo_o`, `rd_o` and `done_o` are all zero.
- R2: With `us_i`=0 and `sat_i`=0, {HI,LO} becomes ({HI,LO} + signed(rs)·signed(rt)) mod 2^64. HI is bits 63:32 and LO is bits 31:0.
- R3: With `us_i`=1 and `sat_i`=0, {HI,LO} becomes ({HI,LO} + unsigned(rs)·unsigned(rt)) mod 2^64. A carry out is discarded.
- R4: On the `done_o` cycle, `rd_o` equals the new `hi_o` when `hi_sel_i` was 1 at start, and the new `lo_o` when it was 0.
- R5: With `us_i`=0 and `sat_i`=1, an exact signed sum above 2^31−1 stores 64'h00000000_7FFFFFFF.
- R6: With `us_i`=0 and `sat_i`=1, an exact signed sum below −2^31 stores 64'hFFFFFFFF_80000000.
- R7: With `us_i`=1 and `sat_i`=1, a sum that carries out of 64 bits stores 64'hFFFFFFFF_FFFFFFFF. There is no low-side clamp in this mode.
- R8: With `sat_i`=1, a sum inside the clamp range is stored exactly. This includes −2^31 (signed) and values above 2^32 (unsigned).
- R9: A start sampled at rising edge N makes `done_o` high for exactly the one cycle after edge N+1. HI, LO and `rd_o` update at that same edge N+1.
- R10: A start presented while an operation is in flight (the cycle after an accepted start) is ignored: no second `done_o` pulse follows and the accumulator is left untouched.
- R11: `hi_wr_i` and `lo_wr_i` load their word at the next rising edge when no operation is in flight. While one is in flight they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an accumulate |
| rs_i | input | 32 | First multiplicand |
| rt_i | input | 32 | Second multiplicand |
| us_i | input | 1 | 1 = unsigned, 0 = signed |
| sat_i | input | 1 | 1 = clamp the result |
| hi_sel_i | input | 1 | 1 = return HI on `rd_o`, 0 = return LO |
| hi_wr_i | input | 1 | Direct load strobe for HI |
| hi_wdata_i | input | 32 | Data for the direct HI load |
| lo_wr_i | input | 1 | Direct load strobe for LO |
| lo_wdata_i | input | 32 | Data for the direct LO load |
| done_o | output | 1 | One-cycle completion pulse |
| rd_o | output | 32 | Destination-register result |
| hi_o | output | 32 | Accumulator upper word |
| lo_o | output | 32 | Accumulator lower word |

## Verification
Inputs are driven and outputs are sampled on falling edges. A start driven before edge N is therefore seen low on `done_o` at the first falling edge after N. It is then seen high, with the new HI, LO and `rd_o`, at the falling edge after N+1, and low again one cycle later. Each of those three points is checked separately.

A direct load is checked one falling edge after its strobe. The ignored-start and ignored-load cases are judged on the cycles after the completion pulse, when a second pulse or a changed word would otherwise appear. Expected sums come from a 128-bit reference computed in the bench. The clamp constants are also compared as literals.

// File: rtl/mac_pkg.sv
package mac_pkg;
   // control bits captured with an accepted start
   typedef struct packed {
      logic us;
      logic sat;
      logic hi_sel;
   } mac_ctl_t;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
   parameter int OPW = 32
) (
   input  logic [OPW-1:0]   a_i,
   input  logic [OPW-1:0]   b_i,
   input  logic             us_i,
   output logic [2*OPW-1:0] prod_o
);
   localparam int XW = OPW + 1;   // one guard bit turns unsigned into signed
   localparam int PW = 2 * XW;

   logic signed [XW-1:0] ax, bx;
   logic signed [PW-1:0] full;

   always_comb begin
      ax     = $signed({~us_i & a_i[OPW-1], a_i});
      bx     = $signed({~us_i & b_i[OPW-1], b_i});
      full   = PW'(ax) * PW'(bx);
      prod_o = full[2*OPW-1:0];
   end

   // full signed product of two XW-bit values fits in 2*XW-1 bits; top two agree
   always_comb begin
      assert (full[PW-1] == full[PW-2]) else $error("p_prod_fit_r2 violated");
   end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
   parameter int OPW    = 32,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [2*OPW-1:0] acc_i,
   input  logic [2*OPW-1:0] prod_i,
   input  logic             us_i,
   input  logic             sat_i,
   output logic [2*OPW-1:0] res_o
);
   localparam int AW = 2 * OPW;
   localparam int EW = AW + 2;    // exact sum of two AW-bit values, either mode
   localparam logic signed [EW-1:0] POS_LIM = (EW'(1) << (OPW-1)) - EW'(1);
   localparam logic signed [EW-1:0] NEG_LIM = -(EW'(1) << (OPW-1));

   logic signed [EW-1:0] acc_x, prod_x, sum_x;

   always_comb begin
      acc_x  = us_i ? {2'b00, acc_i}  : {{2{acc_i[AW-1]}},  acc_i};
      prod_x = us_i ? {2'b00, prod_i} : {{2{prod_i[AW-1]}}, prod_i};
      sum_x  = acc_x + prod_x;
   end

   generate
      if (SAT_EN) begin : g_sat
         logic s_ovf, s_udf, u_ovf;
         always_comb begin
            s_ovf = sum_x > POS_LIM;
            s_udf = sum_x < NEG_LIM;
            u_ovf = sum_x[AW];
            if (!sat_i)     res_o = sum_x[AW-1:0];
            else if (us_i)  res_o = u_ovf ? {AW{1'b1}} : sum_x[AW-1:0];
            else if (s_ovf) res_o = POS_LIM[AW-1:0];
            else if (s_udf) res_o = NEG_LIM[AW-1:0];
            else            res_o = sum_x[AW-1:0];
         end
      end else begin : g_wrap
         assign res_o = sum_x[AW-1:0];
      end
   endgenerate
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit #(
   parameter int OPW    = 32,
   parameter bit SAT_EN = 1'b1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           start_i,
   input  logic [OPW-1:0] rs_i,
   input  logic [OPW-1:0] rt_i,
   input  logic           us_i,
   input  logic           sat_i,
   input  logic           hi_sel_i,
   input  logic           hi_wr_i,
   input  logic [OPW-1:0] hi_wdata_i,
   input  logic           lo_wr_i,
   input  logic [OPW-1:0] lo_wdata_i,
   output logic           done_o,
   output logic [OPW-1:0] rd_o,
   output logic [OPW-1:0] hi_o,
   output logic [OPW-1:0] lo_o
);
   import mac_pkg::*;

   localparam int AW = 2 * OPW;

   generate
      if (OPW < 4) begin : g_bad_width
         $error("sat_mac_unit: OPW must be at least 4");
      end
   endgenerate

   logic           busy_q, done_q;
   mac_ctl_t       ctl_q;
   logic [AW-1:0]  prod_d, prod_q, res_d;
   logic [OPW-1:0] hi_q, lo_q, rd_q;
   logic           accept;

   assign accept = start_i & ~busy_q;

   mac_product #(.OPW(OPW)) u_prod (
      .a_i   (rs_i),
      .b_i   (rt_i),
      .us_i  (us_i),
      .prod_o(prod_d)
   );

   mac_accum #(.OPW(OPW), .SAT_EN(SAT_EN)) u_acc (
      .acc_i (({hi_q, lo_q})),
      .prod_i(prod_q),
      .us_i  (ctl_q.us),
      .sat_i (ctl_q.sat),
      .res_o (res_d)
   );

   // stage 1: capture product and controls
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         prod_q <= '0;
         ctl_q  <= '0;
      end else begin
         busy_q <= accept;
         if (accept) begin
            prod_q <= prod_d;
            ctl_q  <= '{us: us_i, sat: sat_i, hi_sel: hi_sel_i};
         end
      end
   end

   // stage 2: accumulate, or direct loads when idle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_q <= 1'b0;
         hi_q   <= '0;
         lo_q   <= '0;
         rd_q   <= '0;
      end else begin
         done_q <= busy_q;
         if (busy_q) begin
            hi_q <= res_d[AW-1:OPW];
            lo_q <= res_d[OPW-1:0];
            rd_q <= ctl_q.hi_sel ? res_d[AW-1:OPW] : res_d[OPW-1:0];
         end else begin
            if (hi_wr_i) hi_q <= hi_wdata_i;
            if (lo_wr_i) lo_q <= lo_wdata_i;
         end
      end
   end

   assign done_o = done_q;
   assign rd_o   = rd_q;
   assign hi_o   = hi_q;
   assign lo_o   = lo_q;

   // ---------------- assertions ----------------
   p_done_follows_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> done_q) else $error("p_done_follows_busy_r9");

   p_done_needs_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> $past(busy_q)) else $error("p_done_needs_busy_r9");

   p_single_flight_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> !busy_q) else $error("p_single_flight_r10");

   p_hi_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q && !hi_wr_i) |=> $stable(hi_q)) else $error("p_hi_hold_r11");

   p_lo_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_q && !lo_wr_i) |=> $stable(lo_q)) else $error("p_lo_hold_r11");

   p_rd_mirror_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> (rd_o == (ctl_q.hi_sel ? hi_q : lo_q))) else $error("p_rd_mirror_r4");

   p_signed_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q && ctl_q.sat && !ctl_q.us) |-> (hi_q == {OPW{lo_q[OPW-1]}}))
      else $error("p_signed_clamp_r5");
endmodule

// File: tb/sat_mac_unit_bench.sv
module sat_mac_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, us = 1'b0, sat = 1'b0, hsel = 1'b0;
   logic [31:0] rs = '0, rt = '0;
   logic        hwr = 1'b0, lwr = 1'b0;
   logic [31:0] hwd = '0, lwd = '0;
   logic        done;
   logic [31:0] rd, hi, lo;
   int          n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   sat_mac_unit u_sat_mac_unit (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rs_i(rs), .rt_i(rt),
      .us_i(us), .sat_i(sat), .hi_sel_i(hsel),
      .hi_wr_i(hwr), .hi_wdata_i(hwd), .lo_wr_i(lwr), .lo_wdata_i(lwd),
      .done_o(done), .rd_o(rd), .hi_o(hi), .lo_o(lo)
   );

   function automatic logic [63:0] ref_mac(logic [63:0] acc, logic [31:0] a, logic [31:0] b,
                                           logic u, logic s);
      logic signed [127:0] av, bv, cv, sv;
      av = u ? {96'd0, a} : {{96{a[31]}}, a};
      bv = u ? {96'd0, b} : {{96{b[31]}}, b};
      cv = u ? {64'd0, acc} : {{64{acc[63]}}, acc};
      sv = av * bv + cv;
      if (s && !u) begin
         if (sv > 128'sd2147483647)  return 64'h0000_0000_7FFF_FFFF;
         if (sv < -128'sd2147483648) return 64'hFFFF_FFFF_8000_0000;
      end
      if (s && u && sv > 128'sd18446744073709551615) return 64'hFFFF_FFFF_FFFF_FFFF;
      return sv[63:0];
   endfunction

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic load_acc(logic [63:0] v);
      @(negedge clk);
      hwr = 1'b1; lwr = 1'b1; hwd = v[63:32]; lwd = v[31:0];
      @(negedge clk);
      hwr = 1'b0; lwr = 1'b0;
      check("R11", "direct load", {hi, lo}, v);
   endtask

   task automatic run_op(string req, logic u, logic s, logic hs, logic [31:0] a, logic [31:0] b);
      logic [63:0] exp;
      exp = ref_mac({hi, lo}, a, b, u, s);
      start = 1'b1; us = u; sat = s; hsel = hs; rs = a; rt = b;
      @(negedge clk);
      start = 1'b0;
      check("R9", "done low after first edge", 64'(done), 64'd0);
      @(negedge clk);
      check("R9", "done high after second edge", 64'(done), 64'd1);
      check(req, "HI:LO", {hi, lo}, exp);
      check("R4", "rd mirror", 64'(rd), 64'(hs ? exp[63:32] : exp[31:0]));
      @(negedge clk);
      check("R9", "done single pulse", 64'(done), 64'd0);
   endtask

   task automatic t_reset();
      check("R1", "HI:LO reset", {hi, lo}, 64'd0);
      check("R1", "rd reset", 64'(rd), 64'd0);
      check("R1", "done reset", 64'(done), 64'd0);
   endtask

   task automatic t_signed();
      load_acc(64'd0);
      run_op("R2", 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFD, 32'd7);
      check("R2", "-21 literal", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFEB);
      run_op("R2", 1'b0, 1'b0, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      load_acc(64'h1234_5678_9ABC_DEF0);
      run_op("R2", 1'b0, 1'b0, 1'b1, -32'sd100000, 32'd300000);
      load_acc(64'h7FFF_FFFF_FFFF_FFFF);
      run_op("R2", 1'b0, 1'b0, 1'b0, 32'd1, 32'd1);
      check("R2", "signed wrap literal", {hi, lo}, 64'h8000_0000_0000_0000);
   endtask

   task automatic t_unsigned();
      load_acc(64'd0);
      run_op("R3", 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      check("R3", "max product literal", {hi, lo}, 64'hFFFF_FFFE_0000_0001);
      load_acc(64'hFFFF_FFFF_FFFF_FFFF);
      run_op("R3", 1'b1, 1'b0, 1'b0, 32'd2, 32'd1);
      check("R3", "carry dropped", {hi, lo}, 64'd1);
   endtask

   task automatic t_sat_signed();
      load_acc(64'h0000_0000_7FFF_FFF0);
      run_op("R5", 1'b0, 1'b1, 1'b0, 32'h10, 32'd1);
      check("R5", "positive clamp", {hi, lo}, 64'h0000_0000_7FFF_FFFF);
      load_acc(64'h0000_0001_0000_0000);
      run_op("R5", 1'b0, 1'b1, 1'b1, 32'd0, 32'd0);
      check("R5", "large acc clamp", {hi, lo}, 64'h0000_0000_7FFF_FFFF);
      load_acc(64'd0);
      run_op("R8", 1'b0, 1'b1, 1'b0, 32'h8000_0000, 32'd1);
      check("R8", "exact negative limit", {hi, lo}, 64'hFFFF_FFFF_8000_0000);
      load_acc(64'd0);
      run_op("R6", 1'b0, 1'b1, 1'b1, 32'h8000_0000, 32'd2);
      check("R6", "negative clamp", {hi, lo}, 64'hFFFF_FFFF_8000_0000);
   endtask

   task automatic t_sat_unsigned();
      load_acc(64'hFFFF_FFFF_FFFF_FFF0);
      run_op("R7", 1'b1, 1'b1, 1'b0, 32'h20, 32'd1);
      check("R7", "all-ones clamp", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFF);
      load_acc(64'h0000_0005_0000_0000);
      run_op("R8", 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd2);
      check("R8", "unsigned above 2^32 exact", {hi, lo}, 64'h0000_0006_FFFF_FFFE);
   endtask

   task automatic t_busy_start();
      logic [63:0] exp;
      load_acc(64'd10);
      exp = ref_mac(64'd10, 32'd3, 32'd4, 1'b0, 1'b0);
      start = 1'b1; us = 1'b0; sat = 1'b0; hsel = 1'b0; rs = 32'd3; rt = 32'd4;
      @(negedge clk);
      rs = 32'd1000; rt = 32'd1000;   // second start while in flight
      @(negedge clk);
      start = 1'b0;
      check("R10", "first result kept", {hi, lo}, exp);
      @(negedge clk);
      check("R10", "no second done", 64'(done), 64'd0);
      @(negedge clk);
      check("R10", "still no done", 64'(done), 64'd0);
      check("R10", "acc untouched", {hi, lo}, exp);
   endtask

   task automatic t_busy_write();
      logic [63:0] exp;
      load_acc(64'd5);
      exp = ref_mac(64'd5, 32'd6, 32'd7, 1'b1, 1'b0);
      start = 1'b1; us = 1'b1; sat = 1'b0; hsel = 1'b0; rs = 32'd6; rt = 32'd7;
      @(negedge clk);
      start = 1'b0;
      hwr = 1'b1; lwr = 1'b1; hwd = 32'hDEAD_BEEF; lwd = 32'hCAFE_F00D;
      @(negedge clk);
      hwr = 1'b0; lwr = 1'b0;
      check("R11", "loads ignored in flight", {hi, lo}, exp);
      @(negedge clk);
      check("R11", "acc after ignored load", {hi, lo}, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_signed();
      t_unsigned();
      t_sat_signed();
      t_sat_unsigned();
      t_busy_start();
      t_busy_write();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule